// File: doc/BRIEF.md
# LIN Break Detector with Synch-Field Wait

This block watches the receive line of a UART that is running in LIN mode. Each bit time it samples the line on a bit-rate tick. If it counts eleven or more ticks in a row with the line low, it has found a break. It then raises a sticky break flag and sends a single-cycle clear strobe to the receiver's four status flags (framing error, overrun error, parity error and data-full). It also enters a wait state for the synch field that follows.

The wait state ends in one of two ways. The line may return high and then fall again, which marks the start bit of the synch byte; the block then emits a one-cycle hand-off pulse for the baud measurement logic. Or software may issue a reset. A reset is accepted only while the transmitter is enabled. It also recovers the block when the wait state was entered by something that was not a real break. Break detection runs only when LIN mode is selected.

Top module: `lin_brk_det`

## Requirements
- R1: After `rst_n` is released, `brk_flag`, `sync_wait`, `sync_start` and `rx_flag_clr` are all 0.
- R2: When 11 consecutive `bit_tick` pulses each see `rxd` at 0 in LIN mode, `brk_flag` and `sync_wait` are 1 from the clock edge that samples the 11th tick. Ten such ticks leave `brk_flag` at 0.
- R3: If `rxd` is 1 at any clock edge, the low-time count restarts from zero. For example, 10 low ticks, then 1 high tick, then 10 low ticks do not set `brk_flag`.
- R4: While `lin_mode` is 0, no low period of any length sets `brk_flag` or produces a clear strobe.
- R5: On detection, `rx_flag_clr` equals 4'b1111 for exactly one clock cycle. The bit map is: bit 0 framing error, bit 1 overrun error, bit 2 parity error, bit 3 receive-data-full.
- R6: `sync_wait` stays 1 after detection, including while `rxd` sits high after the break, until the synch start is seen or a software reset is accepted.
- R7: While waiting, the first falling edge of `rxd` (a clock edge that sees `rxd` at 0 after it has been 1 since the break) does two things. It drives `sync_start` to 1 for exactly one cycle, and it returns `sync_wait` to 0 at the same edge.
- R8: `brk_flag` stays 1 after the synch start. Only a `brk_clr_wr` pulse or an accepted software reset clears it.
- R9: A `sw_rst_req` pulse with `tx_en` at 1 clears `brk_flag`, `sync_wait` and the low-time count. With `tx_en` at 0 it has no effect.
- R10: The low-time count saturates. A low period of 50 ticks produces exactly one clear strobe and does not detect a second break.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rxd | input | 1 | Serial receive line |
| bit_tick | input | 1 | One-cycle pulse per bit time |
| lin_mode | input | 1 | 1 selects LIN operation and enables detection |
| brk_clr_wr | input | 1 | Software write of 0 to the break flag |
| sw_rst_req | input | 1 | Software reset command |
| tx_en | input | 1 | Transmitter enable; gates the software reset |
| brk_flag | output | 1 | Sticky break-detected flag |
| sync_wait | output | 1 | Waiting for the synch field |
| sync_start | output | 1 | One-cycle pulse at the synch byte's start edge |
| rx_flag_clr | output | 4 | Clear strobes for the receiver status flags |

## Verification
The bench tries several patterns:
- Low runs of 3, 10, 11, 12 and 50 ticks in LIN mode, which separate the off-by-one threshold and the saturation corner.
- A 20-tick run with LIN mode off, which shows the mode gate.
- A 10-low, 1-high, 10-low pattern, which tells a restarting counter from an accumulating one.
- A 10-low run cut by a software reset and followed by one more low tick, which shows that the reset clears the count and not only the flags.

The exit from the wait state is driven with a high period and then a falling edge. This separates leaving on the synch start from leaving on the break's own rising edge.

// File: rtl/lin_brk_pkg.sv
package lin_brk_pkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_WAIT_HI = 2'd1,
    ST_WAIT_LO = 2'd2
  } sync_st_e;

  // Next value of the low-time counter: restart on a high line,
  // advance on a tick while low, never exceed the ceiling.
  function automatic int unsigned low_cnt_next(input int unsigned cur,
                                               input logic line_low,
                                               input logic tick,
                                               input int unsigned ceil_v);
    if (!line_low)          return 0;
    else if (!tick)         return cur;
    else if (cur >= ceil_v) return ceil_v;
    else                    return cur + 1;
  endfunction

endpackage

// File: rtl/lin_low_cnt.sv
module lin_low_cnt #(
  parameter int unsigned BRK_BITS = 11,
  parameter int unsigned CNT_MAX  = 31
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic enable,
  input  logic rxd,
  input  logic bit_tick,
  output logic brk_hit
);
  import lin_brk_pkg::*;

  localparam int unsigned CNT_W = $clog2(CNT_MAX + 1);
  localparam logic [CNT_W-1:0] HIT_AT = CNT_W'(BRK_BITS - 1);
  localparam logic [CNT_W-1:0] TOP    = CNT_W'(CNT_MAX);

  logic [CNT_W-1:0] cnt_q;
  logic             line_low;

  assign line_low = enable && !rxd;
  assign brk_hit  = line_low && bit_tick && (cnt_q == HIT_AT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt_q <= '0;
    else if (clr) cnt_q <= '0;
    else          cnt_q <= CNT_W'(low_cnt_next(32'(cnt_q), line_low, bit_tick, CNT_MAX));
  end

  // R10: a saturated count holds while the line stays low
  p_cnt_sat_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == TOP && line_low && !clr) |=> (cnt_q == TOP));

  // R3: a high line empties the count
  p_cnt_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rxd && enable) |=> (cnt_q == '0));

  // R4: detection stays off outside LIN mode
  p_mode_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> !brk_hit);

endmodule

// File: rtl/lin_sync_fsm.sv
module lin_sync_fsm (
  input  logic clk,
  input  logic rst_n,
  input  logic sw_acc,
  input  logic rxd,
  input  logic brk_hit,
  output logic sync_wait,
  output logic sync_start
);
  import lin_brk_pkg::*;

  sync_st_e st_q, st_d;
  logic     start_edge;

  assign start_edge = (st_q == ST_WAIT_LO) && !rxd && !brk_hit;

  always_comb begin
    st_d = st_q;
    if (brk_hit) st_d = ST_WAIT_HI;
    else begin
      unique case (st_q)
        ST_WAIT_HI: if (rxd) st_d = ST_WAIT_LO;
        ST_WAIT_LO: if (!rxd) st_d = ST_IDLE;
        default:    st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      sync_start <= 1'b0;
    end else if (sw_acc) begin
      st_q       <= ST_IDLE;
      sync_start <= 1'b0;
    end else begin
      st_q       <= st_d;
      sync_start <= start_edge;
    end
  end

  assign sync_wait = (st_q != ST_IDLE);

  // R6: a break always leaves the block waiting
  p_wait_after_hit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_hit && !sw_acc) |=> sync_wait);

  // R7: the hand-off pulse is one cycle wide and ends the wait
  p_start_one_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sync_start |=> !sync_start);
  p_start_exit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sync_start |-> !sync_wait);

  // R6: a high line alone never ends the wait
  p_hold_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_wait && rxd && !sw_acc) |=> sync_wait);

endmodule

// File: rtl/lin_brk_flags.sv
module lin_brk_flags #(
  parameter int unsigned N_CLR = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sw_acc,
  input  logic             brk_hit,
  input  logic             brk_clr_wr,
  output logic             brk_flag,
  output logic [N_CLR-1:0] rx_flag_clr
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      brk_flag    <= 1'b0;
      rx_flag_clr <= '0;
    end else begin
      rx_flag_clr <= (brk_hit && !sw_acc) ? '1 : '0;
      if (sw_acc)          brk_flag <= 1'b0;
      else if (brk_hit)    brk_flag <= 1'b1;
      else if (brk_clr_wr) brk_flag <= 1'b0;
    end
  end

  // R5: strobes are all-or-nothing and last one cycle
  p_clr_whole_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_flag_clr == '0) || (rx_flag_clr == '1));
  p_clr_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_flag_clr != '0) |=> (rx_flag_clr == '0));

  // R8: the flag is sticky without a clear or reset
  p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_flag && !brk_clr_wr && !sw_acc) |=> brk_flag);

  // R9: an accepted reset clears the flag
  p_swrst_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sw_acc |=> !brk_flag);

endmodule

// File: rtl/lin_brk_det.sv
module lin_brk_det #(
  parameter int unsigned BRK_BITS = 11,
  parameter int unsigned CNT_MAX  = 31,
  parameter int unsigned N_CLR    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rxd,
  input  logic             bit_tick,
  input  logic             lin_mode,
  input  logic             brk_clr_wr,
  input  logic             sw_rst_req,
  input  logic             tx_en,
  output logic             brk_flag,
  output logic             sync_wait,
  output logic             sync_start,
  output logic [N_CLR-1:0] rx_flag_clr
);

  logic sw_acc;
  logic brk_hit;

  assign sw_acc = sw_rst_req && tx_en;

  lin_low_cnt #(.BRK_BITS(BRK_BITS), .CNT_MAX(CNT_MAX)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clr(sw_acc), .enable(lin_mode),
    .rxd(rxd), .bit_tick(bit_tick), .brk_hit(brk_hit)
  );

  lin_sync_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .sw_acc(sw_acc), .rxd(rxd),
    .brk_hit(brk_hit), .sync_wait(sync_wait), .sync_start(sync_start)
  );

  lin_brk_flags #(.N_CLR(N_CLR)) u_flags (
    .clk(clk), .rst_n(rst_n), .sw_acc(sw_acc), .brk_hit(brk_hit),
    .brk_clr_wr(brk_clr_wr), .brk_flag(brk_flag), .rx_flag_clr(rx_flag_clr)
  );

  // R9: an accepted reset ends the wait state
  p_swrst_wait_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sw_acc |=> !sync_wait);

  // R9: a reset request without transmitter enable changes nothing
  p_swrst_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_rst_req && !tx_en && brk_flag && !brk_clr_wr) |=> brk_flag);

  // R2: flag and wait state rise together
  p_flag_wait_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(brk_flag) |-> sync_wait);

endmodule

// File: tb/test_lin_brk_det.sv
module test_lin_brk_det;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rxd = 1'b1;
  logic       bit_tick = 1'b0;
  logic       lin_mode = 1'b1;
  logic       brk_clr_wr = 1'b0;
  logic       sw_rst_req = 1'b0;
  logic       tx_en = 1'b1;
  logic       brk_flag, sync_wait, sync_start;
  logic [3:0] rx_flag_clr;

  int n_chk = 0;
  int n_fail = 0;
  int str_cnt = 0;
  int sync_cnt = 0;
  logic [3:0] last_clr = 4'h0;

  always #5 clk = ~clk;

  lin_brk_det i_lin_brk_det (
    .clk(clk), .rst_n(rst_n), .rxd(rxd), .bit_tick(bit_tick),
    .lin_mode(lin_mode), .brk_clr_wr(brk_clr_wr), .sw_rst_req(sw_rst_req),
    .tx_en(tx_en), .brk_flag(brk_flag), .sync_wait(sync_wait),
    .sync_start(sync_start), .rx_flag_clr(rx_flag_clr)
  );

  always @(negedge clk) begin
    if (rx_flag_clr != 4'h0) begin
      str_cnt++;
      last_clr = rx_flag_clr;
    end
    if (sync_start) sync_cnt++;
  end

  // vector: {lin_mode, low ticks, expected flag, expected strobe count}
  localparam logic [13:0] VECS [0:5] = '{
    {1'b1, 8'd10, 1'b0, 4'd0},
    {1'b1, 8'd11, 1'b1, 4'd1},
    {1'b1, 8'd12, 1'b1, 4'd1},
    {1'b0, 8'd20, 1'b0, 4'd0},
    {1'b1, 8'd50, 1'b1, 4'd1},
    {1'b1, 8'd3,  1'b0, 4'd0}
  };

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic send(input logic val, input int n);
    for (int i = 0; i < n; i++) begin
      rxd = val;
      bit_tick = 1'b1;
      @(negedge clk);
      bit_tick = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic sw_reset();
    sw_rst_req = 1'b1;
    @(negedge clk);
    sw_rst_req = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 10);
    n_fail++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 brk_flag", int'(brk_flag), 0);
    chk("R1 sync_wait", int'(sync_wait), 0);
    chk("R1 sync_start", int'(sync_start), 0);
    chk("R1 rx_flag_clr", int'(rx_flag_clr), 0);

    // table walk: R2 threshold, R4 mode gate, R10 saturation
    for (int v = 0; v < 6; v++) begin
      rxd = 1'b1;
      lin_mode = VECS[v][13];
      sw_reset();
      str_cnt = 0;
      send(1'b0, int'(VECS[v][12:5]));
      rxd = 1'b1;
      @(negedge clk);
      @(negedge clk);
      chk($sformatf("R2/R4 flag vec%0d", v), int'(brk_flag), int'(VECS[v][4]));
      chk($sformatf("R10 strobes vec%0d", v), str_cnt, int'(VECS[v][3:0]));
    end
    lin_mode = 1'b1;

    // R3: interrupted low period
    sw_reset();
    send(1'b0, 10); send(1'b1, 1); send(1'b0, 10);
    rxd = 1'b1; @(negedge clk);
    chk("R3 flag after split low", int'(brk_flag), 0);

    // R5, R6, R7, R8
    sw_reset();
    str_cnt = 0; sync_cnt = 0; last_clr = 4'h0;
    send(1'b0, 11);
    chk("R6 wait after break", int'(sync_wait), 1);
    chk("R5 strobe value", int'(last_clr), 15);
    chk("R5 strobe count", str_cnt, 1);
    rxd = 1'b1;
    repeat (3) @(negedge clk);
    chk("R6 wait while high", int'(sync_wait), 1);
    chk("R7 no pulse on rise", sync_cnt, 0);
    rxd = 1'b0;
    @(negedge clk);
    chk("R7 pulse at fall", int'(sync_start), 1);
    chk("R7 wait ends", int'(sync_wait), 0);
    @(negedge clk);
    chk("R7 pulse width", int'(sync_start), 0);
    chk("R8 flag sticky", int'(brk_flag), 1);
    brk_clr_wr = 1'b1; @(negedge clk); brk_clr_wr = 1'b0; @(negedge clk);
    chk("R8 flag cleared", int'(brk_flag), 0);
    rxd = 1'b1; @(negedge clk);

    // R9: gated reset
    sw_reset();
    send(1'b0, 11);
    rxd = 1'b1;
    tx_en = 1'b0;
    sw_reset();
    chk("R9 ignored flag", int'(brk_flag), 1);
    chk("R9 ignored wait", int'(sync_wait), 1);
    tx_en = 1'b1;
    sw_reset();
    chk("R9 reset flag", int'(brk_flag), 0);
    chk("R9 reset wait", int'(sync_wait), 0);

    // R9: reset clears the count mid-low
    send(1'b0, 10);
    sw_reset();
    send(1'b0, 1);
    rxd = 1'b1; @(negedge clk);
    chk("R9 count cleared", int'(brk_flag), 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule